// File: doc/BRIEF.md
# Three-Way Intersection Light Controller

The controller drives the go lights for north, south and east traffic at a crossing. Each approach has a car-present input. A detected car sets a sticky request for that approach. A registered go output for that approach turns on when the block's rules allow it, and turns off once the approach reports no car.

North and south traffic do not conflict with each other, so they may be green together. Both conflict with east traffic. One internal lock bit records that the north/south pair is holding the crossing. East may only turn green while that lock is clear. A pending east request keeps north and south from starting a new green. The lock release rules cover the cycles in which north and south switch in the same clock edge, so the lock can neither drop under a live north/south green nor stay set forever. The pins are plain control and status signals. There is no data stream, so there is no valid/ready handshake or back-pressure.

Top module: `xing_light_ctrl`

## Requirements
- R1: While rst_n is low, and at the first edge after it rises, go_n, go_s and go_e are 0, and every request flag and the lock are clear.
- R2: A car input high at a clock edge sets that approach's request flag at that edge. The flag stays set after the car input falls, until that approach's light turns off. A one-cycle car pulse is therefore still served.
- R3: go_n rises at an edge where the north request is set, go_n is 0 and no east request is set. The lock is set at that same edge.
- R4: go_n falls at an edge where go_n is 1 and car_n is 0. The north request clears at that edge. While car_n stays 1, go_n holds.
- R5: go_s follows the R3 and R4 rules, using car_s and the south request.
- R6: go_e rises at an edge where the east request is set, the lock is clear and go_e is 0. It falls, clearing the east request, at an edge where go_e is 1 and car_e is 0.
- R7: go_e is never 1 in the same cycle as go_n or go_s. The lock is set in every cycle where go_n or go_s is 1.
- R8: When north and south turn off at the same edge, the lock clears at that edge, so a waiting east request is served at the next edge.
- R9: When south turns off while north stays green, the lock stays set and east stays red.
- R10: If cars never wait at a green light forever, every request is eventually granted a go for its approach.
- R11: When north turns on at the same edge where south turns off, the lock stays set, because setting the lock wins over releasing it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| car_n | input | 1 | Car present on the north approach |
| car_s | input | 1 | Car present on the south approach |
| car_e | input | 1 | Car present on the east approach |
| go_n | output | 1 | North green, registered |
| go_s | output | 1 | South green, registered |
| go_e | output | 1 | East green, registered |

## Verification
Directed sequences cover the following cases:
- A one-cycle north pulse, which separates a sticky request from a level-sensitive one.
- North and east requesting together, which shows east priority over a new north green.
- North and south turning off together, which separates a correct lock release from a stuck lock.
- South dropping while north stays green, and north starting while south drops. These separate early lock release from a set-over-release priority.

After that, a long stretch of random car patterns with a fixed seed is compared each cycle against a bench model. The same stretch checks that go_e is never green together with go_n or go_s. It also checks that no waiting request goes unserved for longer than a fixed bound.

// File: rtl/xl_pkg.sv
package xl_pkg;
  localparam int NUM_DIRS = 3;
  localparam int NUM_NS   = 2;

  typedef enum int {DIR_N = 0, DIR_S = 1, DIR_E = 2} dir_e;

  typedef struct packed {
    logic turn_on;
    logic turn_off;
  } light_evt_t;
endpackage

// File: rtl/xl_req_flag.sv
module xl_req_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic sense,
  input  logic clear,
  output logic req
);
  // Clearing when the light drops wins over a new sighting.
  always_ff @(posedge clk) begin
    if (!rst_n)     req <= 1'b0;
    else if (clear) req <= 1'b0;
    else if (sense) req <= 1'b1;
  end
endmodule

// File: rtl/xl_ns_light.sv
module xl_ns_light
  import xl_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       req,
  input  logic       sense,
  input  logic       east_req,
  output logic       go,
  output light_evt_t evt
);
  always_comb begin
    evt.turn_on  = req & ~go & ~east_req;
    evt.turn_off = go & ~sense;
  end

  always_ff @(posedge clk) begin
    if (!rst_n)            go <= 1'b0;
    else if (evt.turn_on)  go <= 1'b1;
    else if (evt.turn_off) go <= 1'b0;
  end
endmodule

// File: rtl/xl_east_light.sv
module xl_east_light
  import xl_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       req,
  input  logic       sense,
  input  logic       lock,
  output logic       go,
  output light_evt_t evt
);
  always_comb begin
    evt.turn_on  = req & ~lock & ~go;
    evt.turn_off = go & ~sense;
  end

  always_ff @(posedge clk) begin
    if (!rst_n)            go <= 1'b0;
    else if (evt.turn_on)  go <= 1'b1;
    else if (evt.turn_off) go <= 1'b0;
  end
endmodule

// File: rtl/xl_lock_ctrl.sv
module xl_lock_ctrl
  import xl_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  light_evt_t n_evt,
  input  light_evt_t s_evt,
  input  logic       go_n,
  input  logic       go_s,
  input  logic       sense_s,
  output logic       lock
);
  logic grab, n_release, s_release;

  always_comb begin
    grab      = n_evt.turn_on | s_evt.turn_on;
    // North releases if south is already red or is dropping at the same edge.
    n_release = n_evt.turn_off & (~go_s | ~sense_s);
    // South releases only if north is red and is not about to go green.
    s_release = s_evt.turn_off & ~go_n & ~n_evt.turn_on;
  end

  always_ff @(posedge clk) begin
    if (!rst_n)                     lock <= 1'b0;
    else if (grab)                  lock <= 1'b1;
    else if (n_release | s_release) lock <= 1'b0;
  end
endmodule

// File: rtl/xing_light_ctrl.sv
module xing_light_ctrl
  import xl_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic car_n,
  input  logic car_s,
  input  logic car_e,
  output logic go_n,
  output logic go_s,
  output logic go_e
);
  logic [NUM_DIRS-1:0] sense_v;
  logic [NUM_DIRS-1:0] req_v;
  logic [NUM_DIRS-1:0] go_v;
  light_evt_t          evt [NUM_DIRS];
  logic                lock_q;

  assign sense_v = {car_e, car_s, car_n};

  for (genvar d = 0; d < NUM_DIRS; d++) begin : g_req
    xl_req_flag u_req (
      .clk   (clk),
      .rst_n (rst_n),
      .sense (sense_v[d]),
      .clear (evt[d].turn_off),
      .req   (req_v[d])
    );
  end

  for (genvar d = 0; d < NUM_NS; d++) begin : g_ns
    xl_ns_light u_ns (
      .clk      (clk),
      .rst_n    (rst_n),
      .req      (req_v[d]),
      .sense    (sense_v[d]),
      .east_req (req_v[DIR_E]),
      .go       (go_v[d]),
      .evt      (evt[d])
    );
  end

  xl_east_light u_east (
    .clk   (clk),
    .rst_n (rst_n),
    .req   (req_v[DIR_E]),
    .sense (sense_v[DIR_E]),
    .lock  (lock_q),
    .go    (go_v[DIR_E]),
    .evt   (evt[DIR_E])
  );

  xl_lock_ctrl u_lock (
    .clk     (clk),
    .rst_n   (rst_n),
    .n_evt   (evt[DIR_N]),
    .s_evt   (evt[DIR_S]),
    .go_n    (go_v[DIR_N]),
    .go_s    (go_v[DIR_S]),
    .sense_s (sense_v[DIR_S]),
    .lock    (lock_q)
  );

  assign go_n = go_v[DIR_N];
  assign go_s = go_v[DIR_S];
  assign go_e = go_v[DIR_E];
endmodule

// File: rtl/xl_checker.sv
module xl_checker (
  input logic       clk,
  input logic       rst_n,
  input logic       car_n,
  input logic       car_s,
  input logic       car_e,
  input logic       go_n,
  input logic       go_s,
  input logic       go_e,
  input logic       lock,
  input logic [2:0] req
);
  a_r7_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(go_e && (go_n || go_s)));

  a_r7_lock_covers: assert property (@(posedge clk) disable iff (!rst_n)
    (go_n || go_s) |-> lock);

  a_r2_sticky_set: assert property (@(posedge clk) disable iff (!rst_n)
    car_n |=> req[0]);

  a_r4_north_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (go_n && car_n) |=> go_n);

  a_r4_north_drop: assert property (@(posedge clk) disable iff (!rst_n)
    (go_n && !car_n) |=> (!go_n && !req[0]));

  a_r6_east_drop: assert property (@(posedge clk) disable iff (!rst_n)
    (go_e && !car_e) |=> (!go_e && !req[2]));

  a_r3_north_start: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(go_n) |-> $past(req[0] && !req[2]));
endmodule

bind xing_light_ctrl xl_checker u_chk (
  .clk   (clk),
  .rst_n (rst_n),
  .car_n (car_n),
  .car_s (car_s),
  .car_e (car_e),
  .go_n  (go_n),
  .go_s  (go_s),
  .go_e  (go_e),
  .lock  (lock_q),
  .req   (req_v)
);

// File: tb/sim_xing_light_ctrl.sv
module sim_xing_light_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam int RAND_CYCLES = 4000;
  localparam int WAIT_LIMIT = 300;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic car_n = 1'b0, car_s = 1'b0, car_e = 1'b0;
  logic go_n, go_s, go_e;

  int n_checks = 0;
  int n_fail = 0;

  // Bench model state
  logic m_rn, m_rs, m_re, m_gn, m_gs, m_ge, m_lk;
  int   wait_n, wait_s, wait_e, max_wait;

  always #(CLK_PERIOD/2) clk = ~clk;

  xing_light_ctrl u0 (
    .clk(clk), .rst_n(rst_n),
    .car_n(car_n), .car_s(car_s), .car_e(car_e),
    .go_n(go_n), .go_s(go_s), .go_e(go_e)
  );

  task automatic check(input string req, input logic act, input logic exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0b expected=%0b at %0t", req, act, exp, $time);
    end
  endtask

  function automatic logic [6:0] model_next(input logic [6:0] st,
                                            input logic sn, ss, se);
    logic rn, rs, re, gn, gs, ge, lk;
    logic non, noff, son, soff, eon, eoff;
    {rn, rs, re, gn, gs, ge, lk} = st;
    non  = rn & !gn & !re;
    noff = gn & !sn;
    son  = rs & !gs & !re;
    soff = gs & !ss;
    eon  = re & !lk & !ge;
    eoff = ge & !se;
    return {noff ? 1'b0 : (sn ? 1'b1 : rn),
            soff ? 1'b0 : (ss ? 1'b1 : rs),
            eoff ? 1'b0 : (se ? 1'b1 : re),
            non ? 1'b1 : (noff ? 1'b0 : gn),
            son ? 1'b1 : (soff ? 1'b0 : gs),
            eon ? 1'b1 : (eoff ? 1'b0 : ge),
            (non | son) ? 1'b1 :
            ((noff & (!gs | !ss)) | (soff & !gn & !non)) ? 1'b0 : lk};
  endfunction

  // Drive at negedge, advance one rising edge, sample 1 time unit later.
  task automatic step(input logic sn, ss, se);
    @(negedge clk);
    car_n = sn; car_s = ss; car_e = se;
    @(posedge clk);
    {m_rn, m_rs, m_re, m_gn, m_gs, m_ge, m_lk} =
      model_next({m_rn, m_rs, m_re, m_gn, m_gs, m_ge, m_lk}, sn, ss, se);
    #1;
  endtask

  task automatic expect3(input string req, input logic en, es, ee);
    check(req, go_n, en);
    check(req, go_s, es);
    check(req, go_e, ee);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    n_fail++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end

  initial begin
    {m_rn, m_rs, m_re, m_gn, m_gs, m_ge, m_lk} = '0;
    wait_n = 0; wait_s = 0; wait_e = 0; max_wait = 0;
    void'($urandom(32'd1234));
    repeat (3) @(posedge clk);
    #1;
    expect3("R1 in reset", 0, 0, 0);
    @(negedge clk);
    rst_n = 1'b1;
    step(0, 0, 0);
    expect3("R1 after reset", 0, 0, 0);

    // R2/R3: one-cycle north pulse is remembered
    step(1, 0, 0); expect3("R2 request not yet go", 0, 0, 0);
    step(0, 0, 0); expect3("R2 sticky pulse served", 1, 0, 0);
    // R4: no car north drops go
    step(0, 0, 0); expect3("R4 north off", 0, 0, 0);

    // R3/R6: east request blocks new north green
    step(1, 0, 1); expect3("R3 requests latch", 0, 0, 0);
    step(1, 0, 1); expect3("R6 east wins over north", 0, 0, 1);
    step(1, 0, 0); expect3("R6 east off", 0, 0, 0);
    step(1, 0, 0); expect3("R3 north after east", 1, 0, 0);

    // R5/R9: south drops while north stays
    step(1, 1, 0); expect3("R5 south request", 1, 0, 0);
    step(1, 1, 0); expect3("R5 south on", 1, 1, 0);
    step(1, 0, 1); expect3("R5 south off", 1, 0, 0);
    step(1, 0, 1); expect3("R9 east held by lock", 1, 0, 0);
    step(0, 0, 1); expect3("R4 north off releases", 0, 0, 0);
    step(0, 0, 1); expect3("R6 east after release", 0, 0, 1);
    step(0, 0, 0); expect3("R6 east off again", 0, 0, 0);

    // R8: both off together
    step(1, 1, 0); expect3("R8 requests", 0, 0, 0);
    step(1, 1, 0); expect3("R8 both green", 1, 1, 0);
    step(0, 0, 1); expect3("R8 both off", 0, 0, 0);
    step(0, 0, 1); expect3("R8 east not stuck", 0, 0, 1);
    step(0, 0, 0); expect3("R8 east off", 0, 0, 0);

    // R11: north starts as south drops, lock must survive
    step(0, 1, 0); expect3("R11 south req", 0, 0, 0);
    step(0, 1, 0); expect3("R11 south on", 0, 1, 0);
    step(1, 1, 0); expect3("R11 north req", 0, 1, 0);
    step(0, 0, 0); expect3("R11 swap", 1, 0, 0);
    step(1, 0, 1); expect3("R11 east req", 1, 0, 0);
    step(1, 0, 1); expect3("R11 lock kept", 1, 0, 0);
    step(0, 0, 1); expect3("R11 north off", 0, 0, 0);
    step(0, 0, 1); expect3("R11 east served", 0, 0, 1);
    step(0, 0, 0);

    // Random phase: R7 model compare, R10 bounded wait
    for (int i = 0; i < RAND_CYCLES; i++) begin
      step(($urandom % 8) < 5, ($urandom % 8) < 4, ($urandom % 8) < 4);
      expect3("R7 model compare", m_gn, m_gs, m_ge);
      check("R7 cross exclusion", go_e & (go_n | go_s), 1'b0);
      wait_n = (m_rn && !m_gn) ? wait_n + 1 : 0;
      wait_s = (m_rs && !m_gs) ? wait_s + 1 : 0;
      wait_e = (m_re && !m_ge) ? wait_e + 1 : 0;
      if (wait_n > max_wait) max_wait = wait_n;
      if (wait_s > max_wait) max_wait = wait_s;
      if (wait_e > max_wait) max_wait = wait_e;
    end
    n_checks++;
    if (max_wait > WAIT_LIMIT) begin
      n_fail++;
      $display("FAIL R10 liveness actual=%0d expected<=%0d", max_wait, WAIT_LIMIT);
    end

    $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end
endmodule